// File: doc/BRIEF.md
# Queue-Locality Silent Store Detector

This block runs alongside an in-order-allocated load/store queue and decides, without any extra data cache access, whether a store about to write memory would leave the memory image unchanged. It keeps a small per-slot data array that advances in lock-step with the queue. A load slot can be filled with the whole cache line the load brought in. Each store, once its word address, byte enables and data are presented, writes its own bytes into its slot. When a store is presented, the block looks at every slot that is older than the store, finds the youngest one that touches any of the store's bytes, and compares. If that slot holds all of the store's bytes, the verdict is silent or not silent. Otherwise the store is left undecided and is handled by the normal write path.

Queue bookkeeping enters as plain pulses: allocate at the tail (with a load/store flag), retire at the head, a barrier flush that discards every captured byte, and a line invalidation from the coherence side that discards captured bytes of one line. Store queries enter on a valid/ready channel and verdicts leave on a valid/ready channel with one result register. A query is accepted when `st_valid` and `st_ready` are both high. `st_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays on the outputs, unchanged, until `res_ready` is seen high. The result of an accepted query appears on the cycle after acceptance.

Top module: `ssq_top`

## Requirements
- R1: After reset, `res_valid` is low, `st_ready` is high and no slot holds captured data, so a store presented with no other activity comes back undecided.
- R2: A store whose youngest older overlapping slot is a captured load line is decided. It is reported silent when every enabled byte equals the captured byte, and not silent otherwise.
- R3: Any word of a captured line can be checked. The word address is `{line, word_index}`, where word_index selects word `w` covering line bytes `4w..4w+3`. Bit `k` of `st_be` enables byte `k` of `st_data` (bits `8k+7:8k`), which maps to line byte `4w+k`. Only enabled bytes are compared.
- R4: An older store that has presented its data acts as a comparison source for younger stores. When both an older load line and a younger older-store cover the bytes, the younger (store) data is used.
- R5: If the youngest older slot that overlaps the store's bytes does not hold all of them, the store is undecided.
- R6: An older store slot whose address has not yet been presented blocks any decision for younger stores (undecided).
- R7: Slots younger than the store, slots on other lines, and the absence of any overlapping older slot all lead to an undecided result.
- R8: A barrier flush discards all captured data; later queries are undecided until new data is captured. A query accepted in the same cycle as a flush is undecided.
- R9: An invalidation discards captured data only on its line. Other lines keep deciding normally, and a query to the invalidated line accepted in the same cycle is undecided.
- R10: Retired slots no longer supply data, and slot order follows the queue correctly across the wrap from the last slot back to slot 0.
- R11: While `res_valid` is high and `res_ready` is low, `st_ready` is low and `res_slot`, `res_decided` and `res_silent` hold their values. An accepted query produces `res_valid` with its slot on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate the tail slot |
| alloc_is_store | input | 1 | Allocated slot is a store |
| retire_valid | input | 1 | Retire the head slot |
| ld_cap_valid | input | 1 | Capture a line for a load slot |
| ld_cap_slot | input | IDX_W (5) | Load slot being filled |
| ld_cap_line | input | LINE_AW (27) | Line address of the captured data |
| ld_cap_data | input | LINE_BITS (256) | Captured line, byte b at bits 8b+7:8b |
| st_valid | input | 1 | Store query valid |
| st_ready | output | 1 | Store query accepted when high with st_valid |
| st_slot | input | IDX_W (5) | Queue slot of the store |
| st_waddr | input | WADDR_W (30) | Store word address {line, word_index} |
| st_data | input | WORD_BITS (32) | Store data |
| st_be | input | WORD_BYTES (4) | Store byte enables |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_slot | output | IDX_W (5) | Slot the verdict belongs to |
| res_decided | output | 1 | A covering older slot was found |
| res_silent | output | 1 | Store is silent (meaningful when decided) |
| barrier_flush | input | 1 | Discard all captured data |
| inv_valid | input | 1 | Invalidate one line |
| inv_line | input | LINE_AW (27) | Line address to invalidate |

## Verification
The checks take for granted that the queue never allocates into a full queue or retires from an empty one. They also assume a line is captured only into an allocated load slot, and that each store slot is queried at most once. The bench allocates and retires only through its own slot bookkeeping, resets before most scenarios so slot numbers are known, and captures each load before or after its stores exactly as the scenario intends. Back-pressure is exercised by holding `res_ready` low while a second query waits.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    VD_NONE    = 2'd0,
    VD_BLOCK   = 2'd1,
    VD_SILENT  = 2'd2,
    VD_CHANGED = 2'd3
  } verdict_e;

  function automatic logic vd_decided(verdict_e v);
    return (v == VD_SILENT) || (v == VD_CHANGED);
  endfunction

endpackage

// File: rtl/ssq_slots.sv
module ssq_slots #(
  parameter int DEPTH      = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINE_AW    = 27,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  input  logic                  alloc_is_store,
  input  logic                  retire_valid,
  input  logic                  ld_wr,
  input  logic [IDX_W-1:0]      ld_slot,
  input  logic [LINE_AW-1:0]    ld_line,
  input  logic [LINE_BITS-1:0]  ld_data,
  input  logic                  st_wr,
  input  logic [IDX_W-1:0]      st_slot,
  input  logic [LINE_AW-1:0]    st_line,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic [LINE_BITS-1:0]  st_ldata,
  input  logic                  flush,
  input  logic                  inv_valid,
  input  logic [LINE_AW-1:0]    inv_line,
  output logic [IDX_W-1:0]      head,
  output logic                  occ     [DEPTH],
  output logic                  is_st   [DEPTH],
  output logic                  addr_ok [DEPTH],
  output logic                  data_ok [DEPTH],
  output logic [LINE_AW-1:0]    e_line  [DEPTH],
  output logic [LINE_BYTES-1:0] e_mask  [DEPTH],
  output logic [LINE_BITS-1:0]  e_data  [DEPTH]
);

  logic [IDX_W-1:0] tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (alloc_valid)  tail <= tail + 1'b1;
      if (retire_valid) head <= head + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    logic                 ld_hit, st_hit, al_hit, rt_hit, kill;
    logic [LINE_AW-1:0]   nxt_line;

    assign ld_hit   = ld_wr && (ld_slot == ME);
    assign st_hit   = st_wr && (st_slot == ME);
    assign al_hit   = alloc_valid && (tail == ME);
    assign rt_hit   = retire_valid && (head == ME);
    assign nxt_line = ld_hit ? ld_line : (st_hit ? st_line : e_line[i]);
    assign kill     = flush || (inv_valid && (nxt_line == inv_line));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[i]     <= 1'b0;
        is_st[i]   <= 1'b0;
        addr_ok[i] <= 1'b0;
        data_ok[i] <= 1'b0;
      end else begin
        if (al_hit) begin
          occ[i]     <= 1'b1;
          is_st[i]   <= alloc_is_store;
          addr_ok[i] <= 1'b0;
          data_ok[i] <= 1'b0;
        end else if (rt_hit) begin
          occ[i]     <= 1'b0;
          addr_ok[i] <= 1'b0;
          data_ok[i] <= 1'b0;
        end else begin
          if (ld_hit || st_hit) begin
            addr_ok[i] <= 1'b1;
            data_ok[i] <= !kill;
          end else if (kill) begin
            data_ok[i] <= 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (ld_hit) begin
        e_line[i] <= ld_line;
        e_mask[i] <= '1;
        e_data[i] <= ld_data;
      end else if (st_hit) begin
        e_line[i] <= st_line;
        e_mask[i] <= st_mask;
        e_data[i] <= st_ldata;
      end
    end
  end

endmodule

// File: rtl/ssq_match.sv
module ssq_match
  import ssq_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINE_AW    = 27,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic [IDX_W-1:0]      head,
  input  logic                  occ     [DEPTH],
  input  logic                  is_st   [DEPTH],
  input  logic                  addr_ok [DEPTH],
  input  logic                  data_ok [DEPTH],
  input  logic [LINE_AW-1:0]    e_line  [DEPTH],
  input  logic [LINE_BYTES-1:0] e_mask  [DEPTH],
  input  logic [LINE_BITS-1:0]  e_data  [DEPTH],
  input  logic [IDX_W-1:0]      q_slot,
  input  logic [LINE_AW-1:0]    q_line,
  input  logic [LINE_BYTES-1:0] q_mask,
  input  logic [LINE_BITS-1:0]  q_bits,
  input  logic [LINE_BITS-1:0]  q_ldata,
  output verdict_e              verdict
);

  logic [IDX_W-1:0] q_age;
  logic [IDX_W-1:0] age   [DEPTH];
  logic             rel   [DEPTH];
  logic             ovl   [DEPTH];
  logic             cov   [DEPTH];
  logic             same  [DEPTH];

  assign q_age = q_slot - head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic older, pending;
    assign age[i]  = IDX_W'(i) - head;
    assign older   = occ[i] && (age[i] < q_age);
    assign pending = is_st[i] && !addr_ok[i];
    assign ovl[i]  = addr_ok[i] && (e_line[i] == q_line) && |(e_mask[i] & q_mask);
    assign rel[i]  = older && (pending || ovl[i]);
    assign cov[i]  = data_ok[i] && ((e_mask[i] & q_mask) == q_mask);
    assign same[i] = ((e_data[i] ^ q_ldata) & q_bits) == '0;
  end

  logic             found;
  logic [IDX_W-1:0] best;
  logic [IDX_W-1:0] best_age;

  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rel[i] && (!found || (age[i] > best_age))) begin
        found    = 1'b1;
        best     = IDX_W'(i);
        best_age = age[i];
      end
    end
  end

  always_comb begin
    if (!found)                         verdict = VD_NONE;
    else if (!ovl[best] || !cov[best])  verdict = VD_BLOCK;
    else if (same[best])                verdict = VD_SILENT;
    else                                verdict = VD_CHANGED;
  end

endmodule

// File: rtl/ssq_resp.sv
module ssq_resp
  import ssq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] in_slot,
  input  verdict_e         in_verdict,
  output logic             in_ready,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [IDX_W-1:0] res_slot,
  output logic             res_decided,
  output logic             res_silent
);

  assign in_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_slot    <= '0;
      res_decided <= 1'b0;
      res_silent  <= 1'b0;
    end else if (take) begin
      res_valid   <= 1'b1;
      res_slot    <= in_slot;
      res_decided <= vd_decided(in_verdict);
      res_silent  <= (in_verdict == VD_SILENT);
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/ssq_top.sv
module ssq_top
  import ssq_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 32,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int LINE_OFF_W = $clog2(LINE_BYTES),
  localparam int WORD_OFF_W = $clog2(WORD_BYTES),
  localparam int LINE_AW    = ADDR_W - LINE_OFF_W,
  localparam int WADDR_W    = ADDR_W - WORD_OFF_W,
  localparam int WSEL_W     = LINE_OFF_W - WORD_OFF_W,
  localparam int LINE_BITS  = LINE_BYTES * 8,
  localparam int WORD_BITS  = WORD_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic                 alloc_is_store,
  input  logic                 retire_valid,
  input  logic                 ld_cap_valid,
  input  logic [IDX_W-1:0]     ld_cap_slot,
  input  logic [LINE_AW-1:0]   ld_cap_line,
  input  logic [LINE_BITS-1:0] ld_cap_data,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [IDX_W-1:0]     st_slot,
  input  logic [WADDR_W-1:0]   st_waddr,
  input  logic [WORD_BITS-1:0] st_data,
  input  logic [WORD_BYTES-1:0] st_be,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [IDX_W-1:0]     res_slot,
  output logic                 res_decided,
  output logic                 res_silent,
  input  logic                 barrier_flush,
  input  logic                 inv_valid,
  input  logic [LINE_AW-1:0]   inv_line
);

  logic [LINE_AW-1:0]    q_line;
  logic [WSEL_W-1:0]     q_wsel;
  logic [LINE_BYTES-1:0] q_mask;
  logic [LINE_BITS-1:0]  q_bits;
  logic [LINE_BITS-1:0]  q_ldata;
  logic                  take;
  verdict_e              raw_vd, fin_vd;

  assign q_line  = st_waddr[WADDR_W-1:WSEL_W];
  assign q_wsel  = st_waddr[WSEL_W-1:0];
  assign q_mask  = LINE_BYTES'(st_be) << (32'(q_wsel) * WORD_BYTES);
  assign q_ldata = LINE_BITS'(st_data) << (32'(q_wsel) * WORD_BITS);
  assign take    = st_valid && st_ready;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_bexp
    assign q_bits[8*b +: 8] = {8{q_mask[b]}};
  end

  logic [IDX_W-1:0]      head;
  logic                  occ     [DEPTH];
  logic                  is_st   [DEPTH];
  logic                  addr_ok [DEPTH];
  logic                  data_ok [DEPTH];
  logic [LINE_AW-1:0]    e_line  [DEPTH];
  logic [LINE_BYTES-1:0] e_mask  [DEPTH];
  logic [LINE_BITS-1:0]  e_data  [DEPTH];

  ssq_slots #(
    .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .LINE_AW(LINE_AW)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .retire_valid(retire_valid),
    .ld_wr(ld_cap_valid), .ld_slot(ld_cap_slot),
    .ld_line(ld_cap_line), .ld_data(ld_cap_data),
    .st_wr(take), .st_slot(st_slot), .st_line(q_line),
    .st_mask(q_mask), .st_ldata(q_ldata),
    .flush(barrier_flush), .inv_valid(inv_valid), .inv_line(inv_line),
    .head(head), .occ(occ), .is_st(is_st), .addr_ok(addr_ok),
    .data_ok(data_ok), .e_line(e_line), .e_mask(e_mask), .e_data(e_data)
  );

  ssq_match #(
    .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .LINE_AW(LINE_AW)
  ) u_match (
    .head(head), .occ(occ), .is_st(is_st), .addr_ok(addr_ok),
    .data_ok(data_ok), .e_line(e_line), .e_mask(e_mask), .e_data(e_data),
    .q_slot(st_slot), .q_line(q_line), .q_mask(q_mask),
    .q_bits(q_bits), .q_ldata(q_ldata), .verdict(raw_vd)
  );

  // Data removed in the same cycle cannot back a verdict.
  always_comb begin
    if (barrier_flush || (inv_valid && (inv_line == q_line)))
      fin_vd = VD_BLOCK;
    else
      fin_vd = raw_vd;
  end

  ssq_resp #(.IDX_W(IDX_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .take(take), .in_slot(st_slot), .in_verdict(fin_vd),
    .in_ready(st_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_slot(res_slot),
    .res_decided(res_decided), .res_silent(res_silent)
  );

endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
  parameter int DEPTH   = 32,
  parameter int IDX_W   = 5,
  parameter int LINE_AW = 27,
  parameter int WADDR_W = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_valid,
  input logic               retire_valid,
  input logic               st_valid,
  input logic               st_ready,
  input logic [IDX_W-1:0]   st_slot,
  input logic [WADDR_W-1:0] st_waddr,
  input logic               res_valid,
  input logic               res_ready,
  input logic [IDX_W-1:0]   res_slot,
  input logic               res_decided,
  input logic               res_silent,
  input logic               barrier_flush,
  input logic               inv_valid,
  input logic [LINE_AW-1:0] inv_line
);

  logic [IDX_W:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (alloc_valid && !retire_valid) cnt <= cnt + 1'b1;
    else if (retire_valid && !alloc_valid) cnt <= cnt - 1'b1;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !retire_valid |-> cnt < (IDX_W+1)'(DEPTH));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && !alloc_valid |-> cnt != '0);

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_slot)
      && $stable(res_decided) && $stable(res_silent));

  // R11
  blocked_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !st_ready);

  // R11
  accept_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> res_valid && (res_slot == $past(st_slot)));

  // R8
  flush_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && barrier_flush |=> !res_decided && !res_silent);

  // R9
  inv_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && inv_valid
      && (inv_line == st_waddr[WADDR_W-1:WADDR_W-LINE_AW]) |=> !res_decided);

endmodule

bind ssq_top ssq_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_AW(LINE_AW), .WADDR_W(WADDR_W)
) u_ssq_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .retire_valid(retire_valid),
  .st_valid(st_valid), .st_ready(st_ready), .st_slot(st_slot), .st_waddr(st_waddr),
  .res_valid(res_valid), .res_ready(res_ready), .res_slot(res_slot),
  .res_decided(res_decided), .res_silent(res_silent),
  .barrier_flush(barrier_flush), .inv_valid(inv_valid), .inv_line(inv_line)
);

// File: tb/tb_ssq_top.sv
module tb_ssq_top;

  localparam int IDX_W   = 5;
  localparam int LINE_AW = 27;
  localparam int WADDR_W = 30;
  localparam int LBITS   = 256;
  localparam logic [LINE_AW-1:0] LA = 27'h100;
  localparam logic [LINE_AW-1:0] LB = 27'h101;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               alloc_valid = 0, alloc_is_store = 0, retire_valid = 0;
  logic               ld_cap_valid = 0;
  logic [IDX_W-1:0]   ld_cap_slot = '0;
  logic [LINE_AW-1:0] ld_cap_line = '0;
  logic [LBITS-1:0]   ld_cap_data = '0;
  logic               st_valid = 0, st_ready;
  logic [IDX_W-1:0]   st_slot = '0;
  logic [WADDR_W-1:0] st_waddr = '0;
  logic [31:0]        st_data = '0;
  logic [3:0]         st_be = '0;
  logic               res_valid, res_ready = 1'b1;
  logic [IDX_W-1:0]   res_slot;
  logic               res_decided, res_silent;
  logic               barrier_flush = 0, inv_valid = 0;
  logic [LINE_AW-1:0] inv_line = '0;

  ssq_top dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // {other_line, word_index[2:0], be[3:0], data[31:0], exp_decided, exp_silent}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 3'd0, 4'hF, 32'h43424140, 1'b1, 1'b1},
    {1'b0, 3'd0, 4'hF, 32'h43424141, 1'b1, 1'b0},
    {1'b0, 3'd7, 4'hF, 32'h5F5E5D5C, 1'b1, 1'b1},
    {1'b0, 3'd3, 4'h1, 32'hFFFFFF4C, 1'b1, 1'b1},
    {1'b0, 3'd3, 4'h1, 32'h0000004D, 1'b1, 1'b0},
    {1'b0, 3'd3, 4'hC, 32'h4F4E0000, 1'b1, 1'b1},
    {1'b0, 3'd5, 4'h6, 32'h00565500, 1'b1, 1'b1},
    {1'b1, 3'd0, 4'hF, 32'h43424140, 1'b0, 1'b0}
  };

  function automatic logic [LBITS-1:0] mk_line(logic [7:0] base);
    logic [LBITS-1:0] l;
    for (int b = 0; b < 32; b++) l[8*b +: 8] = base + 8'(b);
    return l;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; res_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc(logic is_st);
    @(negedge clk); alloc_valid = 1'b1; alloc_is_store = is_st;
    @(negedge clk); alloc_valid = 1'b0;
  endtask

  task automatic retire(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); retire_valid = 1'b1;
      @(negedge clk); retire_valid = 1'b0;
    end
  endtask

  task automatic cap(logic [IDX_W-1:0] s, logic [LINE_AW-1:0] ln, logic [7:0] base);
    @(negedge clk); ld_cap_valid = 1'b1; ld_cap_slot = s; ld_cap_line = ln;
    ld_cap_data = mk_line(base);
    @(negedge clk); ld_cap_valid = 1'b0;
  endtask

  task automatic query(string req, logic [IDX_W-1:0] s, logic [LINE_AW-1:0] ln,
                       logic [2:0] w, logic [31:0] d, logic [3:0] be, logic fl,
                       logic exp_dec, logic exp_sil);
    @(negedge clk);
    st_valid = 1'b1; st_slot = s; st_waddr = {ln, w}; st_data = d; st_be = be;
    barrier_flush = fl;
    @(negedge clk);
    st_valid = 1'b0; barrier_flush = 1'b0;
    check(req, "res_valid", 32'(res_valid), 32'd1);
    check(req, "res_slot", 32'(res_slot), 32'(s));
    check(req, "res_decided", 32'(res_decided), 32'(exp_dec));
    check(req, "res_silent", 32'(res_silent), 32'(exp_sil));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle outputs and empty slot array
    check("R1", "res_valid", 32'(res_valid), 0);
    check("R1", "st_ready", 32'(st_ready), 1);
    alloc(1'b1);
    query("R1", 5'd0, LA, 3'd0, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);

    // R2 R3 R7: table of word/byte-lane patterns against one captured line
    for (int v = 0; v < NV; v++) begin
      logic [41:0] e;
      e = VEC[v];
      do_reset();
      alloc(1'b0); alloc(1'b1);
      cap(5'd0, LA, 8'h40);
      query(e[41] ? "R7" : (e[37:34] == 4'hF ? "R2" : "R3"), 5'd1,
            e[41] ? LB : LA, e[40:38], e[33:2], e[37:34], 1'b0, e[1], e[0]);
    end

    // R4: older store overrides older load line
    do_reset();
    alloc(1'b0); alloc(1'b1); alloc(1'b1);
    cap(5'd0, LA, 8'h40);
    query("R4", 5'd1, LA, 3'd0, 32'h11223344, 4'hF, 1'b0, 1'b1, 1'b0);
    query("R4", 5'd2, LA, 3'd0, 32'h11223344, 4'hF, 1'b0, 1'b1, 1'b1);

    // R5: youngest overlapping older slot covers only one byte
    do_reset();
    alloc(1'b0); alloc(1'b1); alloc(1'b1);
    cap(5'd0, LA, 8'h40);
    query("R5", 5'd1, LA, 3'd0, 32'h000000AA, 4'h1, 1'b0, 1'b1, 1'b0);
    query("R5", 5'd2, LA, 3'd0, 32'h434241AA, 4'hF, 1'b0, 1'b0, 1'b0);

    // R6: older store with unknown address blocks
    do_reset();
    alloc(1'b0); alloc(1'b1); alloc(1'b1);
    cap(5'd0, LA, 8'h40);
    query("R6", 5'd2, LA, 3'd0, 32'h43424140, 4'hF, 1'b0, 1'b0, 1'b0);
    query("R7", 5'd1, LB, 3'd0, 32'h43424140, 4'hF, 1'b0, 1'b0, 1'b0);

    // R7: younger load is ignored
    do_reset();
    alloc(1'b1); alloc(1'b0);
    cap(5'd1, LA, 8'h40);
    query("R7", 5'd0, LA, 3'd0, 32'h43424140, 4'hF, 1'b0, 1'b0, 1'b0);

    // R8: flush before and during a query
    do_reset();
    alloc(1'b0); alloc(1'b1); alloc(1'b1);
    cap(5'd0, LA, 8'h40);
    @(negedge clk); barrier_flush = 1'b1;
    @(negedge clk); barrier_flush = 1'b0;
    query("R8", 5'd1, LA, 3'd1, 32'h47464544, 4'hF, 1'b0, 1'b0, 1'b0);
    cap(5'd0, LA, 8'h40);
    query("R8", 5'd2, LA, 3'd2, 32'h4B4A4948, 4'hF, 1'b1, 1'b0, 1'b0);

    // R9: invalidation is per line
    do_reset();
    alloc(1'b0); alloc(1'b0); alloc(1'b1); alloc(1'b1); alloc(1'b1);
    cap(5'd0, LA, 8'h40);
    cap(5'd1, LB, 8'h80);
    @(negedge clk); inv_valid = 1'b1; inv_line = LA;
    @(negedge clk); inv_valid = 1'b0;
    query("R9", 5'd2, LA, 3'd0, 32'h43424140, 4'hF, 1'b0, 1'b0, 1'b0);
    query("R9", 5'd3, LB, 3'd0, 32'h83828180, 4'hF, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    st_valid = 1'b1; st_slot = 5'd4; st_waddr = {LB, 3'd0}; st_data = 32'h83828180;
    st_be = 4'hF; inv_valid = 1'b1; inv_line = LB;
    @(negedge clk);
    st_valid = 1'b0; inv_valid = 1'b0;
    check("R9", "res_decided same-cycle inv", 32'(res_decided), 0);

    // R10: wrap from slot 31 to slot 0, then retire the sources
    do_reset();
    for (int k = 0; k < 30; k++) begin
      alloc(1'b0); retire(1);
    end
    alloc(1'b0); alloc(1'b1); alloc(1'b1);
    cap(5'd30, LA, 8'h40);
    query("R10", 5'd31, LA, 3'd1, 32'h47464544, 4'hF, 1'b0, 1'b1, 1'b1);
    query("R10", 5'd0, LA, 3'd1, 32'h47464544, 4'hF, 1'b0, 1'b1, 1'b1);
    retire(3);
    alloc(1'b1);
    query("R10", 5'd1, LA, 3'd1, 32'h47464544, 4'hF, 1'b0, 1'b0, 1'b0);

    // R11: back-pressure holds the result and stalls the next query
    do_reset();
    alloc(1'b0); alloc(1'b1); alloc(1'b1);
    cap(5'd0, LA, 8'h40);
    @(negedge clk);
    res_ready = 1'b0;
    st_valid = 1'b1; st_slot = 5'd1; st_waddr = {LA, 3'd0}; st_data = 32'h43424140; st_be = 4'hF;
    @(negedge clk);
    st_slot = 5'd2; st_data = 32'h0;
    check("R11", "res_slot", 32'(res_slot), 1);
    check("R11", "st_ready", 32'(st_ready), 0);
    @(negedge clk);
    check("R11", "res_valid held", 32'(res_valid), 1);
    check("R11", "res_slot held", 32'(res_slot), 1);
    check("R11", "res_silent held", 32'(res_silent), 1);
    res_ready = 1'b1;
    @(negedge clk);
    st_valid = 1'b0;
    check("R11", "res_slot next", 32'(res_slot), 2);
    check("R11", "res_decided next", 32'(res_decided), 1);
    check("R11", "res_silent next", 32'(res_silent), 0);
    @(negedge clk);
    check("R11", "res_valid drained", 32'(res_valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule